// File: doc/BRIEF.md
# Multiplexed LED grid scanner with key matrix sampling

This block drives a common-cathode LED panel by time multiplexing. It walks through four or five grid slots, then adds one key-scan slot, and repeats. In each grid slot it fetches the two display-RAM bytes that belong to that grid. It enables the grid and its segments for an on-time chosen by a 3-bit brightness code. The on-time follows a non-linear table of sixteenths of the slot.

One output pin is shared between two roles. In the four-grid mode it is an eighth segment. In the five-grid mode it is the fifth grid.

During the key slot the seven segment lines act as key sources. They are raised one at a time, and the single key return line is sampled for each one. The sampled bits are published together in a 7-bit key register once per scan cycle. The display on/off flag only blanks the panel. Key scanning runs in either state.

Top module: `led_grid_scanner`

## Requirements
- R1: Grid outputs are active low. At most one is low at a time. Grid slot s (0..3) drives grid_n bit s low only while that slot is lit.
- R2: While grid slot s is lit, seg_out[6:0] equals bits 6..0 of RAM byte 2s. Bit 0 drives the first segment. In every other grid-slot sub-tick, seg_out is zero.
- R3: The shared pin has two roles. With mode_sel=0 (4 grids) it is an active-high segment, equal to bit 5 of RAM byte 2s+1 while slot s is lit, and 0 otherwise. With mode_sel=1 (5 grids) it is an active-low grid: it is 0 only while grid slot 4 is lit, and 1 otherwise.
- R4: Each slot has 16 sub-ticks, numbered 0..15, and sub-tick 0 is always blank. Grid slot s is lit in sub-ticks 1..W. W is 1, 2, 4, 10, 11, 12, 13 or 14 for dim_code values 0..7.
- R5: A scan cycle consists of the grid slots (4 or 5), then one key slot. Each slot is 16×PRESCALE clocks long. mode_sel is taken at reset and at each cycle boundary only.
- R6: With disp_on=0, grid slots show all grids high, seg_out zero, and the shared pin in its inactive level.
- R7: In the key slot all grids are high and the shared pin is inactive. seg_out is 1<<k in sub-tick 2k+1 for k=0..6, and zero in the other sub-ticks. This holds regardless of disp_on.
- R8: Key register bit k takes the key_in value sampled in the last clock of key-slot sub-tick 2k+1. key_reg changes only on the last clock of a scan cycle.
- R9: Reset puts the scan at slot 0 sub-tick 0 and clears key_reg. In that state all grids are high and seg_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0: 4 grids / 8 segments, 1: 5 grids / 7 segments |
| disp_on | input | 1 | Display enable |
| dim_code | input | 3 | Brightness code |
| ram_addr | output | 4 | Display RAM read address |
| ram_rdata | input | 8 | RAM data for ram_addr, valid in the same cycle |
| key_in | input | 1 | Key return line, synchronous to clk |
| grid_n | output | 4 | Grid drives 1..4, active low |
| seg_out | output | 7 | Segment drives / key sources, active high |
| shared_out | output | 1 | Eighth segment or fifth grid, depending on mode |
| key_reg | output | 7 | Latched key states |

## Verification
A vector table places the scan at chosen slot and sub-tick positions across both modes, several brightness codes and both display states. It samples exactly at the last lit sub-tick and at the first dark one, so an off-by-one in the brightness table or a misrouted RAM byte shows up directly. The RAM holds a distinct value in every byte, so a swapped grid or byte order gives a visible mismatch. Key tests press an irregular key pattern with the display off. They read the key register one clock before and at the cycle boundary, then release some keys to check that cleared bits drop. A mode flip in the middle of a cycle checks that the shared pin changes role only after the boundary.

// File: rtl/grid_scan_pkg.sv
package grid_scan_pkg;

    localparam int SUBTICKS   = 16;
    localparam int SUB_W      = $clog2(SUBTICKS);
    localparam int SLOT_W     = 3;
    localparam int KEYS       = 7;
    localparam int SEG_W      = 7;
    localparam int GRID_PINS  = 4;
    localparam int SHARED_BIT = 5;

    typedef enum logic {
        MODE_G4S8 = 1'b0,
        MODE_G5S7 = 1'b1
    } scan_mode_e;

    typedef struct packed {
        scan_mode_e            mode;
        logic [SLOT_W-1:0]     slot;
        logic [SUB_W-1:0]      sub;
        logic                  key_slot;
        logic                  fetch_lo;
        logic                  fetch_hi;
        logic                  sub_end;
        logic                  cycle_end;
    } scan_pos_t;

    function automatic logic [SLOT_W-1:0] grid_count(input scan_mode_e m);
        return (m == MODE_G5S7) ? SLOT_W'(5) : SLOT_W'(4);
    endfunction

    function automatic logic [SUB_W:0] dim_width(input logic [2:0] code);
        logic [SUB_W:0] w;
        case (code)
            3'd0:    w = 5'd1;
            3'd1:    w = 5'd2;
            3'd2:    w = 5'd4;
            3'd3:    w = 5'd10;
            3'd4:    w = 5'd11;
            3'd5:    w = 5'd12;
            3'd6:    w = 5'd13;
            default: w = 5'd14;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/grid_scan_timer.sv
module grid_scan_timer
    import grid_scan_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      mode_sel,
    output scan_pos_t pos,
    output logic [3:0] ram_addr
);
    localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBTICKS - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [SUB_W-1:0]  sub_q;
    logic [SLOT_W-1:0] slot_q;
    scan_mode_e        mode_q;
    logic [SLOT_W-1:0] key_idx;
    logic              pre_end;
    logic              cyc_end;

    initial begin
        prescale_min_chk: assert (PRESCALE >= 2)
            else $error("PRESCALE must be at least 2");
    end

    assign key_idx = grid_count(mode_q);
    assign pre_end = (pre_q == PRE_LAST);
    assign cyc_end = pre_end && (sub_q == SUB_LAST) && (slot_q == key_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            sub_q  <= '0;
            slot_q <= '0;
            mode_q <= scan_mode_e'(mode_sel);
        end else if (pre_end) begin
            pre_q <= '0;
            if (sub_q == SUB_LAST) begin
                sub_q <= '0;
                if (slot_q == key_idx) begin
                    slot_q <= '0;
                    mode_q <= scan_mode_e'(mode_sel);
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_comb begin
        pos.mode      = mode_q;
        pos.slot      = slot_q;
        pos.sub       = sub_q;
        pos.key_slot  = (slot_q == key_idx);
        pos.fetch_lo  = (sub_q == '0) && (pre_q == PRE_W'(0));
        pos.fetch_hi  = (sub_q == '0) && (pre_q == PRE_W'(1));
        pos.sub_end   = pre_end;
        pos.cycle_end = cyc_end;
    end

    assign ram_addr = {slot_q[2:0], pre_q[0]};

    // R5
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot_q <= grid_count(mode_q));

    // R5
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_end |=> $stable(mode_q));

endmodule

// File: rtl/grid_seg_driver.sv
module grid_seg_driver
    import grid_scan_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  scan_pos_t            pos,
    input  logic                 disp_on,
    input  logic [2:0]           dim_code,
    input  logic [7:0]           ram_rdata,
    output logic [GRID_PINS-1:0] grid_n,
    output logic [SEG_W-1:0]     seg_out,
    output logic                 shared_out
);
    logic [SEG_W-1:0] lo_q;
    logic             hi_q;
    logic             lit;
    logic [SEG_W-1:0] key_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= 1'b0;
        end else begin
            if (pos.fetch_lo) lo_q <= ram_rdata[SEG_W-1:0];
            if (pos.fetch_hi) hi_q <= ram_rdata[SHARED_BIT];
        end
    end

    assign lit = !pos.key_slot && disp_on && (pos.sub != '0)
                 && ({1'b0, pos.sub} <= dim_width(dim_code));

    for (genvar g = 0; g < GRID_PINS; g++) begin : g_grid
        assign grid_n[g] = !(lit && (pos.slot == SLOT_W'(g)));
    end

    for (genvar k = 0; k < SEG_W; k++) begin : g_keysrc
        assign key_src[k] = pos.key_slot && (pos.sub == SUB_W'(2 * k + 1));
    end

    assign seg_out = pos.key_slot ? key_src : (lit ? lo_q : '0);

    assign shared_out = (pos.mode == MODE_G5S7)
                        ? !(lit && (pos.slot == SLOT_W'(4)))
                        : (lit && hi_q);

    // R1
    grid_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~grid_n));

    // R4
    sub_zero_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (pos.sub == '0 && !pos.key_slot) |-> (seg_out == '0 && grid_n == '1));

    // R6
    disp_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!disp_on && !pos.key_slot) |-> (seg_out == '0 && grid_n == '1));

    // R7
    key_slot_drive_chk: assert property (@(posedge clk) disable iff (rst)
        pos.key_slot |-> (grid_n == '1 && $onehot0(seg_out)));

endmodule

// File: rtl/key_scan_latch.sv
module key_scan_latch
    import grid_scan_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  scan_pos_t       pos,
    input  logic            key_in,
    output logic [KEYS-1:0] key_reg
);
    logic [KEYS-1:0] shadow_q;
    logic [KEYS-1:0] take;

    for (genvar k = 0; k < KEYS; k++) begin : g_take
        assign take[k] = pos.key_slot && pos.sub_end
                         && (pos.sub == SUB_W'(2 * k + 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            key_reg  <= '0;
        end else if (pos.cycle_end) begin
            key_reg  <= shadow_q;
            shadow_q <= '0;
        end else begin
            for (int k = 0; k < KEYS; k++) begin
                if (take[k]) shadow_q[k] <= key_in;
            end
        end
    end

    // R8
    key_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pos.cycle_end |=> $stable(key_reg));

    // R8
    one_take_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take));

endmodule

// File: rtl/led_grid_scanner.sv
module led_grid_scanner
    import grid_scan_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_sel,
    input  logic       disp_on,
    input  logic [2:0] dim_code,
    output logic [3:0] ram_addr,
    input  logic [7:0] ram_rdata,
    input  logic       key_in,
    output logic [3:0] grid_n,
    output logic [6:0] seg_out,
    output logic       shared_out,
    output logic [6:0] key_reg
);
    scan_pos_t pos;

    grid_scan_timer #(.PRESCALE(PRESCALE)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .pos      (pos),
        .ram_addr (ram_addr)
    );

    grid_seg_driver i_drive (
        .clk        (clk),
        .rst        (rst),
        .pos        (pos),
        .disp_on    (disp_on),
        .dim_code   (dim_code),
        .ram_rdata  (ram_rdata),
        .grid_n     (grid_n),
        .seg_out    (seg_out),
        .shared_out (shared_out)
    );

    key_scan_latch i_keys (
        .clk     (clk),
        .rst     (rst),
        .pos     (pos),
        .key_in  (key_in),
        .key_reg (key_reg)
    );

endmodule

// File: tb/test_led_grid_scanner.sv
module test_led_grid_scanner;

    localparam int P = 2;
    localparam int SLOT_CLK = 16 * P;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_sel = 1'b0;
    logic       disp_on = 1'b0;
    logic [2:0] dim_code = 3'd0;
    logic [3:0] ram_addr;
    logic [7:0] ram_rdata;
    logic       key_in;
    logic [3:0] grid_n;
    logic [6:0] seg_out;
    logic       shared_out;
    logic [6:0] key_reg;
    logic [6:0] press = '0;
    logic [7:0] mem [16];

    int total = 0;
    int bad = 0;
    int pos_n = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign ram_rdata = mem[ram_addr];
    assign key_in    = |(seg_out & press);

    led_grid_scanner #(.PRESCALE(P)) i_led_grid_scanner (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .disp_on(disp_on),
        .dim_code(dim_code), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .key_in(key_in), .grid_n(grid_n), .seg_out(seg_out),
        .shared_out(shared_out), .key_reg(key_reg)
    );

    // fields: [12] mode, [11:9] dim, [8] on, [7:5] slot, [4:1] sub, [0] lit
    localparam logic [12:0] VEC [12] = '{
        {1'b0, 3'd0, 1'b1, 3'd0, 4'd1,  1'b1},
        {1'b0, 3'd0, 1'b1, 3'd0, 4'd2,  1'b0},
        {1'b0, 3'd3, 1'b1, 3'd1, 4'd10, 1'b1},
        {1'b0, 3'd3, 1'b1, 3'd1, 4'd11, 1'b0},
        {1'b0, 3'd7, 1'b1, 3'd2, 4'd14, 1'b1},
        {1'b0, 3'd7, 1'b1, 3'd2, 4'd15, 1'b0},
        {1'b0, 3'd7, 1'b1, 3'd3, 4'd0,  1'b0},
        {1'b1, 3'd2, 1'b1, 3'd4, 4'd4,  1'b1},
        {1'b1, 3'd2, 1'b1, 3'd4, 4'd5,  1'b0},
        {1'b1, 3'd5, 1'b0, 3'd2, 4'd3,  1'b0},
        {1'b0, 3'd6, 1'b1, 3'd3, 4'd13, 1'b1},
        {1'b1, 3'd4, 1'b1, 3'd0, 4'd11, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic restart(input logic m, input logic [2:0] d, input logic on);
        rst = 1'b1;
        mode_sel = m;
        dim_code = d;
        disp_on  = on;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        pos_n = 0;
        #1;
    endtask

    task automatic go_to(input int n);
        while (pos_n < n) begin
            @(posedge clk);
            pos_n++;
        end
        #2;
    endtask

    initial begin
        for (int a = 0; a < 16; a++) mem[a] = 8'(a * 8'h17) ^ 8'h3C;

        // R9: reset state
        restart(1'b0, 3'd7, 1'b1);
        check("R9 grid", int'(grid_n), 4'hF);
        check("R9 seg", int'(seg_out), 0);
        check("R9 key", int'(key_reg), 0);

        // R1 R2 R3 R4 R6: table walk
        for (int i = 0; i < 12; i++) begin
            logic m, on, lt;
            logic [2:0] d, s;
            logic [3:0] sb;
            int eg, es, esh;
            {m, d, on, s, sb, lt} = VEC[i];
            restart(m, d, on);
            go_to(int'(s) * SLOT_CLK + int'(sb) * P);
            eg  = (lt && s < 4) ? (~(1 << s) & 4'hF) : 4'hF;
            es  = lt ? int'(mem[2 * s][6:0]) : 0;
            if (m) esh = (lt && s == 4) ? 0 : 1;
            else   esh = lt ? int'(mem[2 * s + 1][5]) : 0;
            check("R1 grid", int'(grid_n), eg);
            check("R2 R4 R6 seg", int'(seg_out), es);
            check("R3 shared", int'(shared_out), esh);
        end

        // R7 R8: key scan with display off
        restart(1'b0, 3'd0, 1'b0);
        press = 7'b1010011;
        go_to(4 * SLOT_CLK + 7 * P);
        check("R7 keysrc", int'(seg_out), 7'b0001000);
        check("R7 grid", int'(grid_n), 4'hF);
        check("R7 shared", int'(shared_out), 0);
        go_to(4 * SLOT_CLK + 8 * P);
        check("R7 gap", int'(seg_out), 0);
        go_to(5 * SLOT_CLK - 1);
        check("R8 hold", int'(key_reg), 0);
        go_to(5 * SLOT_CLK);
        check("R8 latch", int'(key_reg), 7'b1010011);
        press = 7'b0100001;
        go_to(10 * SLOT_CLK - 1);
        check("R8 hold2", int'(key_reg), 7'b1010011);
        go_to(10 * SLOT_CLK);
        check("R8 release", int'(key_reg), 7'b0100001);

        // R5: mode change applies at the cycle boundary only
        press = '0;
        restart(1'b0, 3'd7, 1'b1);
        go_to(10);
        mode_sel = 1'b1;
        go_to(4 * SLOT_CLK + P);
        check("R5 keyslot", int'(seg_out), 1);
        check("R5 grid", int'(grid_n), 4'hF);
        check("R5 shared", int'(shared_out), 0);
        go_to(5 * SLOT_CLK + 4 * SLOT_CLK + P);
        check("R5 gr5", int'(shared_out), 0);
        check("R5 seg", int'(seg_out), int'(mem[8][6:0]));
        go_to(5 * SLOT_CLK + 5 * SLOT_CLK + P);
        check("R5 key after 5", int'(seg_out), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule